// File: doc/BRIEF.md
# Weighted Random State Detector

This block stands in for the measurement step of an emulated quantum register. A host computes, off the chip, how likely each computational basis state is to be observed. It writes those likelihoods into a small on-chip table as unsigned fractions. When a measurement is requested, the block draws a pseudo-random number and reports one basis state index. Each state is chosen with a likelihood equal to its share of the full fraction range.

A single measurement can give the wrong answer, so a probabilistic computation is run as many repeated trials. The block therefore accepts a fresh request in the same cycle that the previous result is presented. The table holds `2^Q_BITS` entries. Every measurement takes a fixed number of cycles equal to the table depth, because the table is scanned one entry per clock.

Top module: `wsd_top`

## Requirements
- R1: Synchronous active-low reset clears every weight to zero, drives `meas_done` low and `meas_state` to 0, and loads the generator with the seed 32'h1D87_2B41.
- R2: When `wt_we` is high at a rising edge, `wt_data` replaces the weight at index `wt_addr`. The new weight governs all later measurements.
- R3: The generator is a 32-bit shift register that moves left by one bit. The new bit 0 is the XOR of bits 31, 21, 1 and 0 (polynomial x^32+x^22+x^2+x+1). It advances exactly once for each accepted request and never otherwise.
- R4: The draw used by a measurement is bits [31:16] of the generator value after that request's advance.
- R5: The reported state is the smallest index i for which the draw is strictly less than the sum of weights 0..i. With eight weights of 16'h2000, this is draw[15:13].
- R6: When the draw is greater than or equal to the sum of all weights, including the case where every weight is zero, the last index (`2^Q_BITS-1`) is reported.
- R7: `meas_done` is a one-cycle pulse. It appears exactly `2^Q_BITS` rising edges after the edge that accepted the request. `meas_state` holds the result from that pulse until the next result.
- R8: A request seen while a measurement is in progress is ignored. It causes no extra result and no generator advance.
- R9: A request is accepted when no measurement is in progress, including in the cycle where `meas_done` is high. Holding `meas_req` high therefore yields one result every `2^Q_BITS+1` cycles.
- R10: A state whose weight is zero is never reported, unless it is the last index reached through R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| wt_we | input | 1 | Weight write enable |
| wt_addr | input | Q_BITS | Basis state index to write |
| wt_data | input | W_BITS | Weight as an unsigned fraction of 2^W_BITS |
| meas_req | input | 1 | Measurement request |
| meas_done | output | 1 | One-cycle pulse marking a valid result |
| meas_state | output | Q_BITS | Detected basis state index |

## Verification
The bench aims at the following corner cases:
- **All-zero table.** A block that forgot the fallback would report a stale index or state 0 instead of the last index.
- **Single non-zero weight.** Weight 16'hFFFF sits in a middle slot. This catches an off-by-one comparison (less-or-equal against strict less-than) and any report of a zero-weight neighbour.
- **Partial total.** The weights sum to far less than one, so most draws fall beyond the sum and must land on the last index.
- **Held request and requests during a scan.** Holding `meas_req` high and pulsing it mid-scan exposes a design that restarts its scan, emits extra pulses or advances its generator on ignored requests. Any of these would shift every later draw and break the cycle-exact comparison.

// File: rtl/wsd_pkg.sv
// Package for the weighted state detector.
// Holds the generator width, its seed and its next-state function.
// Assumes a 32-bit generator and weights no wider than 32 bits.
package wsd_pkg;
    localparam int LFSR_W = 32;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 32'h1D87_2B41;

    // One left shift step; feedback taps are bits 31, 21, 1 and 0.
    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] cur);
        return {cur[LFSR_W-2:0], cur[31] ^ cur[21] ^ cur[1] ^ cur[0]};
    endfunction
endpackage

// File: rtl/wsd_weight_table.sv
// Weight table: one register per basis state, written through a simple port.
// Assumes writes are issued only while no measurement is scanning.
module wsd_weight_table #(
    parameter int Q_BITS = 3,
    parameter int W_BITS = 16,
    localparam int NSTATE = 1 << Q_BITS
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [Q_BITS-1:0]        wr_addr,
    input  logic [W_BITS-1:0]        wr_data,
    output logic [NSTATE*W_BITS-1:0] weights_flat
);
    for (genvar g = 0; g < NSTATE; g++) begin : g_entry
        logic [W_BITS-1:0] entry_q;
        // Load this entry when its index is addressed; clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                entry_q <= '0;
            else if (wr_en && (wr_addr == Q_BITS'(g)))
                entry_q <= wr_data;
        end
        assign weights_flat[g*W_BITS +: W_BITS] = entry_q;
    end
endmodule

// File: rtl/wsd_lfsr.sv
// Maximal-length pseudo-random generator; advances only when stepped.
// Assumes the seed is non-zero.
module wsd_lfsr
    import wsd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    output logic [LFSR_W-1:0] state_q
);
    // Seed on reset, advance one step per accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= LFSR_SEED;
        else if (step)
            state_q <= lfsr_step(state_q);
    end
endmodule

// File: rtl/wsd_scan.sv
// Cumulative scan: walks the table one entry per clock and accumulates the
// weights. It records the first index whose running sum exceeds the draw.
// After the last entry it reports that index, or the last index when no sum
// exceeded the draw. Assumes the draw and the weights are steady while busy.
module wsd_scan #(
    parameter int Q_BITS = 3,
    parameter int W_BITS = 16,
    localparam int NSTATE = 1 << Q_BITS,
    localparam int CUM_W  = W_BITS + Q_BITS
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [W_BITS-1:0]        draw,
    input  logic [NSTATE*W_BITS-1:0] weights_flat,
    output logic                     busy,
    output logic                     done,
    output logic [Q_BITS-1:0]        state
);
    localparam logic [Q_BITS-1:0] LAST_IDX = Q_BITS'(NSTATE - 1);

    logic [Q_BITS-1:0] idx_q;
    logic [CUM_W-1:0]  cum_q;
    logic              found_q;
    logic [Q_BITS-1:0] hit_idx_q;
    logic [W_BITS-1:0] w_cur;
    logic [CUM_W-1:0]  cum_nxt;
    logic              hit;
    logic              last;

    // Current weight, the next running sum and the first-hit test.
    always_comb begin
        w_cur   = weights_flat[idx_q*W_BITS +: W_BITS];
        cum_nxt = cum_q + CUM_W'(w_cur);
        hit     = !found_q && (CUM_W'(draw) < cum_nxt);
        last    = (idx_q == LAST_IDX);
    end

    // Scan sequencing, first-hit capture and result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            done      <= 1'b0;
            state     <= '0;
            idx_q     <= '0;
            cum_q     <= '0;
            found_q   <= 1'b0;
            hit_idx_q <= '0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy    <= 1'b1;
                idx_q   <= '0;
                cum_q   <= '0;
                found_q <= 1'b0;
            end else if (busy) begin
                cum_q <= cum_nxt;
                idx_q <= idx_q + 1'b1;
                if (hit) begin
                    found_q   <= 1'b1;
                    hit_idx_q <= idx_q;
                end
                if (last) begin
                    busy  <= 1'b0;
                    done  <= 1'b1;
                    state <= hit ? idx_q : (found_q ? hit_idx_q : LAST_IDX);
                end
            end
        end
    end
endmodule

// File: rtl/wsd_top.sv
// Weighted random state detector top.
// An accepted request advances the generator once. The scan then compares the
// upper generator bits with the running weight sum over 2^Q_BITS cycles.
// Assumes W_BITS <= 32 and that the host writes weights only between scans.
module wsd_top
    import wsd_pkg::*;
#(
    parameter int Q_BITS = 3,
    parameter int W_BITS = 16,
    localparam int NSTATE = 1 << Q_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wt_we,
    input  logic [Q_BITS-1:0] wt_addr,
    input  logic [W_BITS-1:0] wt_data,
    input  logic              meas_req,
    output logic              meas_done,
    output logic [Q_BITS-1:0] meas_state
);
    logic [NSTATE*W_BITS-1:0] weights_flat;
    logic [LFSR_W-1:0]        lfsr_q;
    logic                     scan_busy;
    logic                     accept;

    // A request is taken only when no scan is running.
    assign accept = meas_req && !scan_busy;

    wsd_weight_table #(.Q_BITS(Q_BITS), .W_BITS(W_BITS)) u_table (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wt_we),
        .wr_addr      (wt_addr),
        .wr_data      (wt_data),
        .weights_flat (weights_flat)
    );

    wsd_lfsr u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (accept),
        .state_q (lfsr_q)
    );

    wsd_scan #(.Q_BITS(Q_BITS), .W_BITS(W_BITS)) u_scan (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (meas_req),
        .draw         (lfsr_q[LFSR_W-1 -: W_BITS]),
        .weights_flat (weights_flat),
        .busy         (scan_busy),
        .done         (meas_done),
        .state        (meas_state)
    );
endmodule

// File: rtl/wsd_checker.sv
// Checker for wsd_top: result timing, generator behaviour and zero-weight
// exclusion. Attached to the top through bind below.
module wsd_checker #(
    parameter int Q_BITS = 3,
    parameter int W_BITS = 16,
    localparam int NSTATE = 1 << Q_BITS
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     meas_req,
    input logic                     meas_done,
    input logic [Q_BITS-1:0]        meas_state,
    input logic                     scan_busy,
    input logic [31:0]              lfsr_q,
    input logic [NSTATE*W_BITS-1:0] weights_flat
);
    logic [Q_BITS:0] lat_cnt;

    // Counts edges since the accepting edge, for the latency check.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lat_cnt <= '0;
        else if (meas_req && !scan_busy)
            lat_cnt <= '0;
        else if (scan_busy)
            lat_cnt <= lat_cnt + 1'b1;
    end

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        meas_done |=> !meas_done);

    p_done_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        meas_done |-> (lat_cnt == (Q_BITS+1)'(NSTATE)));

    p_accept_starts_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_req && !scan_busy) |=> scan_busy);

    p_lfsr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(meas_req && !scan_busy) |=> $stable(lfsr_q));

    p_lfsr_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != 32'd0);

    p_zero_weight_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_done && (meas_state != Q_BITS'(NSTATE - 1)))
            |-> (weights_flat[meas_state*W_BITS +: W_BITS] != '0));
endmodule

bind wsd_top wsd_checker #(.Q_BITS(Q_BITS), .W_BITS(W_BITS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .meas_req     (meas_req),
    .meas_done    (meas_done),
    .meas_state   (meas_state),
    .scan_busy    (scan_busy),
    .lfsr_q       (lfsr_q),
    .weights_flat (weights_flat)
);

// File: tb/wsd_top_tb.sv
`timescale 1ns/1ps
// Bench for wsd_top: a behavioural reference model, compared on every clock.
module wsd_top_tb;
    localparam int Q = 3;
    localparam int N = 1 << Q;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wt_we = 1'b0;
    logic [Q-1:0] wt_addr = '0;
    logic [15:0]  wt_data = '0;
    logic         meas_req = 1'b0;
    logic         meas_done;
    logic [Q-1:0] meas_state;

    int    n_checks = 0;
    int    n_fails = 0;
    string cur_tag = "R1";

    wsd_top #(.Q_BITS(Q), .W_BITS(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .wt_we(wt_we), .wt_addr(wt_addr),
        .wt_data(wt_data), .meas_req(meas_req), .meas_done(meas_done),
        .meas_state(meas_state)
    );

    always #4 clk = ~clk;

    // Reference model state.
    logic [31:0] m_gen;
    int          m_w [N];
    int          cyc = 0;
    int          m_done_edge = -1;
    int          m_exp_state = 0;

    // R5/R6: smallest index whose running sum exceeds the draw, else the last.
    function automatic int pick(input int draw);
        int sum = 0;
        for (int i = 0; i < N; i++) begin
            sum += m_w[i];
            if (draw < sum) return i;
        end
        return N - 1;
    endfunction

    // Model update at each rising edge: writes first, then request acceptance.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_gen = 32'h1D87_2B41;
            for (int i = 0; i < N; i++) m_w[i] = 0;
            m_done_edge = -1;
        end else begin
            if (wt_we) m_w[wt_addr] = wt_data;          // R2
            if (meas_req && cyc > m_done_edge) begin    // R8 / R9
                m_gen = {m_gen[30:0], m_gen[31] ^ m_gen[21] ^ m_gen[1] ^ m_gen[0]}; // R3
                m_exp_state = pick(int'(m_gen[31:16])); // R4
                m_done_edge = cyc + N;                  // R7
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Compare against the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check(meas_done == (cyc == m_done_edge), "R7 done timing",
                  int'(meas_done), int'(cyc == m_done_edge));
            if (cyc == m_done_edge)
                check(meas_state == Q'(m_exp_state), cur_tag,
                      int'(meas_state), m_exp_state);
        end
    end

    task automatic write_w(input int a, input int d);
        @(negedge clk);
        wt_we = 1'b1; wt_addr = Q'(a); wt_data = 16'(d);
        @(negedge clk);
        wt_we = 1'b0;
    endtask

    task automatic measure(input int count);
        for (int k = 0; k < count; k++) begin
            @(negedge clk); meas_req = 1'b1;
            @(negedge clk); meas_req = 1'b0;
            repeat (N + 1) @(negedge clk);
        end
    endtask

    task automatic fill(input int d);
        for (int i = 0; i < N; i++) write_w(i, d);
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports.
        check(meas_done == 1'b0, "R1 done after reset", int'(meas_done), 0);
        check(meas_state == '0, "R1 state after reset", int'(meas_state), 0);

        // R1/R6: an all-zero table always reports the last index.
        cur_tag = "R6 zero table";
        measure(4);

        // R2/R5: uniform weights cover the whole range.
        cur_tag = "R5 uniform";
        fill(16'h2000);
        measure(20);

        // R10: a single full weight in slot 5, neighbours zero.
        cur_tag = "R10 single weight";
        fill(0);
        write_w(5, 16'hFFFF);
        measure(12);

        // R6: partial total; most draws fall past the sum.
        cur_tag = "R6 partial total";
        write_w(5, 0);
        write_w(0, 16'h1000);
        write_w(1, 16'h1000);
        measure(12);

        // R3/R4: skewed weights, so the exact draw sequence matters.
        cur_tag = "R3/R4 skewed";
        write_w(2, 16'h3000);
        write_w(3, 16'h0800);
        write_w(6, 16'h5000);
        write_w(7, 16'h0400);
        measure(16);

        // R9: request held high gives back-to-back results.
        cur_tag = "R9 back-to-back";
        @(negedge clk); meas_req = 1'b1;
        repeat (6 * (N + 1)) @(negedge clk);
        meas_req = 1'b0;
        repeat (N + 2) @(negedge clk);

        // R8: extra pulses during a scan are ignored.
        cur_tag = "R8 busy request";
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); meas_req = 1'b1;
            @(negedge clk); meas_req = 1'b0;
            @(negedge clk); meas_req = 1'b1;
            @(negedge clk); meas_req = 1'b0;
            repeat (N + 1) @(negedge clk);
        end

        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule